// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block moves a byte-wide word between two ports, called A and B, in one direction at a time. Each direction owns a storage register. The A-side register is filled from port A by its own capture strobe. The B-side register is filled from port B by a second strobe. On the port being driven, a per-direction select picks one of two sources: the live word arriving on the opposite port, or the word held in that direction's register. An active-low output enable and a direction input choose which port is driven, if any. Each port has separate input, output and per-bit enable vectors, so the block needs no internal tristate nets.

Everything runs on a single system clock. The capture strobes are asynchronous. Each one passes through a synchronizer and a rising-edge detector, and then loads its register from the port value present in the cycle the edge is seen. Captures never stop: they continue while the block is isolated and while either port is driven. The drive state is held in a small state machine with five named states:

- `ST_RESET`: entered while reset is held.
- `ST_ISOLATE`: neither port is driven.
- `ST_DRIVE_B`: port B is driven from the A side.
- `ST_DRIVE_A`: port A is driven from the B side.
- `ST_TURN`: a one-cycle state in which neither port is driven, used when the direction is reversed.

Transitions of the state machine:

- Any state goes to `ST_RESET` while reset is low.
- `ST_RESET`, `ST_ISOLATE` and `ST_TURN` go to the state requested by the enable and direction inputs.
- `ST_DRIVE_B` goes to `ST_TURN` when port A is requested, and otherwise goes to the requested state.
- `ST_DRIVE_A` goes to `ST_TURN` when port B is requested, and otherwise goes to the requested state.

Top module: `bixcvr_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both stored registers become zero and both enable vectors are all zero after that edge.
- R2: A rising edge on `stb_ab` loads the A-side register with the value `a_in` has two clock edges after the edge on which `stb_ab` is first sampled high (the edge-detect cycle). The A-side register keeps its value otherwise.
- R3: A rising edge on `stb_ba` loads the B-side register from `b_in` with the same timing as R2.
- R4: When `oe_n` is sampled high (1 = disabled), both enable vectors are all zero in the next cycle. Captures (R2, R3) still take place during that time.
- R5: `a_oe` and `b_oe` are never both non-zero in the same cycle.
- R6: When the drive state is port B and port A is requested, or the reverse, exactly one cycle passes with neither port driven before the new port is driven.
- R7: While port B is driven, `b_out` equals `a_in` in the same cycle when `sel_ab` is 0 (live), and equals the A-side register when `sel_ab` is 1 (stored).
- R8: While port A is driven, `a_out` equals `b_in` in the same cycle when `sel_ba` is 0, and equals the B-side register when `sel_ba` is 1.
- R9: An output port that is not driven presents all zeros on its data output.
- R10: With `oe_n` = 0, `dir` = 1 requests port B and `dir` = 0 requests port A. The request shows on the enable vectors one clock after it is sampled. Each enable vector is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1: drive port B from A side; 0: drive port A from B side |
| sel_ab | input | 1 | Source for port B: 0 live `a_in`, 1 A-side register |
| sel_ba | input | 1 | Source for port A: 0 live `b_in`, 1 B-side register |
| stb_ab | input | 1 | Asynchronous capture strobe for the A-side register |
| stb_ba | input | 1 | Asynchronous capture strobe for the B-side register |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Value to drive onto port A |
| a_oe | output | 8 | Per-bit drive enable for port A |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Value to drive onto port B |
| b_oe | output | 8 | Per-bit drive enable for port B |

## Verification
The live paths are combinational, so `a_out` and `b_out` follow the opposite port's input within the same cycle. Port enables change one edge after `oe_n` and `dir` are sampled. A reversal adds one more cycle in which neither port is driven. A stored value becomes visible two edges after the strobe is first sampled high.

The bench changes every input at the falling edge and compares all outputs shortly afterwards. Its behavioural model advances at the rising edge, using a queue of past strobe samples and a mode number. Each output it predicts therefore already includes every register stage of latency.

// File: rtl/bixcvr_pkg.sv
package bixcvr_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_ISOLATE = 3'd1,
        ST_DRIVE_B = 3'd2,
        ST_DRIVE_A = 3'd3,
        ST_TURN    = 3'd4
    } drive_st_t;

    // Drive state requested by the enable and direction inputs
    function automatic drive_st_t requested_state(input logic oe_n, input logic dir);
        if (oe_n)
            return ST_ISOLATE;
        else if (dir)
            return ST_DRIVE_B;
        else
            return ST_DRIVE_A;
    endfunction

endpackage

// File: rtl/bixcvr_strobe_edge.sv
module bixcvr_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= strobe;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Last synchronized sample high, the one before it low
    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/bixcvr_capture_reg.sv
module bixcvr_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/bixcvr_drive_fsm.sv
module bixcvr_drive_fsm
    import bixcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic dir,
    output logic drive_a,
    output logic drive_b
);
    drive_st_t state_q, state_d, want;

    assign want = requested_state(oe_n, dir);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:   state_d = want;
            ST_ISOLATE: state_d = want;
            ST_TURN:    state_d = want;
            ST_DRIVE_B: state_d = (want == ST_DRIVE_A) ? ST_TURN : want;
            ST_DRIVE_A: state_d = (want == ST_DRIVE_B) ? ST_TURN : want;
            default:    state_d = ST_ISOLATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        unique case (state_q)
            ST_DRIVE_B: drive_b = 1'b1;
            ST_DRIVE_A: drive_a = 1'b1;
            default: begin
                drive_a = 1'b0;
                drive_b = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bixcvr_top.sv
module bixcvr_top #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             stb_ab,
    input  logic             stb_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

    logic [NDIR-1:0]            strobe_v;
    logic [NDIR-1:0]            rise_v;
    logic [NDIR-1:0][WIDTH-1:0] src_v;
    logic [NDIR-1:0][WIDTH-1:0] held_v;
    logic                       drive_a, drive_b;

    assign strobe_v = {stb_ba, stb_ab};
    assign src_v[0] = a_in;
    assign src_v[1] = b_in;

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            bixcvr_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .strobe(strobe_v[d]),
                .rise  (rise_v[d])
            );
            bixcvr_capture_reg #(.WIDTH(WIDTH)) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .load (rise_v[d]),
                .d    (src_v[d]),
                .q    (held_v[d])
            );
        end
    endgenerate

    bixcvr_drive_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .dir    (dir),
        .drive_a(drive_a),
        .drive_b(drive_b)
    );

    always_comb begin
        b_oe  = {WIDTH{drive_b}};
        a_oe  = {WIDTH{drive_a}};
        b_out = drive_b ? (sel_ab ? held_v[0] : a_in) : '0;
        a_out = drive_a ? (sel_ba ? held_v[1] : b_in) : '0;
    end

endmodule

// File: rtl/bixcvr_checker.sv
module bixcvr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_n,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_oe
);
    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe))); // R5

    AST_ISOLATE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (a_oe == '0 && b_oe == '0)); // R4

    AST_TURN_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
        (|a_oe) |=> !(|b_oe)); // R6

    AST_TURN_FROM_B: assert property (@(posedge clk) disable iff (!rst_n)
        (|b_oe) |=> !(|a_oe)); // R6

    AST_B_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|b_oe) && !sel_ab) |-> (b_out == a_in)); // R7

    AST_A_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|a_oe) && !sel_ba) |-> (a_out == b_in)); // R8

    AST_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
        !(|a_oe) |-> (a_out == '0)); // R9

    AST_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
        !(|b_oe) |-> (b_out == '0)); // R9

    AST_ENABLE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_oe == '0) || (a_oe == '1)) && ((b_oe == '0) || (b_oe == '1))); // R10

endmodule

bind bixcvr_top bixcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .oe_n  (oe_n),
    .sel_ab(sel_ab),
    .sel_ba(sel_ba),
    .a_in  (a_in),
    .b_in  (b_in),
    .a_out (a_out),
    .b_out (b_out),
    .a_oe  (a_oe),
    .b_oe  (b_oe)
);

// File: tb/sim_bixcvr_top.sv
`timescale 1ns/1ps
module sim_bixcvr_top;
    logic       clk = 1'b0;
    logic       rst_n, oe_n, dir, sel_ab, sel_ba, stb_ab, stb_ba;
    logic [7:0] a_in, b_in, a_out, b_out, a_oe, b_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    bixcvr_top u0 (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Behavioural model. Mode: 0 reset, 1 isolate, 2 drive B, 3 drive A, 4 turnaround.
    int         m_mode = 0;
    logic [7:0] m_ra = '0, m_rb = '0;
    bit         h_ab[$];
    bit         h_ba[$];

    function automatic int want_mode(input logic oen, input logic d);
        if (oen) return 1;
        return d ? 2 : 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ra = '0; m_rb = '0;
            h_ab = {0, 0, 0};
            h_ba = {0, 0, 0};
        end else begin
            int w;
            w = want_mode(oe_n, dir);
            // Entry 1 is the newest settled sample, entry 2 the one before it
            if (h_ab[1] && !h_ab[2]) m_ra = a_in;
            if (h_ba[1] && !h_ba[2]) m_rb = b_in;
            h_ab.push_front(stb_ab); void'(h_ab.pop_back());
            h_ba.push_front(stb_ba); void'(h_ba.pop_back());
            if ((m_mode == 2 && w == 3) || (m_mode == 3 && w == 2)) m_mode = 4;
            else m_mode = w;
        end
    end

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0] e_aoe, e_boe, e_aout, e_bout;
        string t_en, t_a, t_b;
        e_boe  = (m_mode == 2) ? 8'hFF : 8'h00;
        e_aoe  = (m_mode == 3) ? 8'hFF : 8'h00;
        e_bout = (m_mode == 2) ? (sel_ab ? m_ra : a_in) : 8'h00;
        e_aout = (m_mode == 3) ? (sel_ba ? m_rb : b_in) : 8'h00;
        case (m_mode)
            0: t_en = "R1";
            1: t_en = "R4";
            4: t_en = "R6";
            default: t_en = "R10";
        endcase
        t_b = (m_mode != 2) ? "R9" : (sel_ab ? "R2" : "R7");
        t_a = (m_mode != 3) ? "R9" : (sel_ba ? "R3" : "R8");
        check8(t_en, "b_oe", b_oe, e_boe);
        check8(t_en, "a_oe", a_oe, e_aoe);
        check8(t_b, "b_out", b_out, e_bout);
        check8(t_a, "a_out", a_out, e_aout);
        n_cmp++;
        if ((|a_oe) && (|b_oe)) begin
            n_bad++;
            $display("FAIL R5 both enables: actual %h/%h expected one zero", a_oe, b_oe);
        end
    endtask

    task automatic step(input logic oen, input logic d, input logic sab, input logic sba,
                        input logic sta, input logic stb, input logic [7:0] av, input logic [7:0] bv);
        @(negedge clk);
        oe_n = oen; dir = d; sel_ab = sab; sel_ba = sba;
        stb_ab = sta; stb_ba = stb; a_in = av; b_in = bv;
        #1 compare_all();
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        stb_ab = 1'b0; stb_ba = 1'b0; a_in = 8'h00; b_in = 8'h00;
        // R1: reset state
        repeat (3) step(0, 1, 1, 1, 0, 0, 8'h5A, 8'hA5);
        @(negedge clk); rst_n = 1'b1;
        // R4 with R2/R3: both registers capture while isolated
        step(1, 0, 0, 0, 0, 0, 8'h11, 8'h22);
        step(1, 0, 0, 0, 1, 1, 8'h33, 8'h44);
        step(1, 0, 0, 0, 1, 1, 8'h55, 8'h66);
        step(1, 0, 0, 0, 1, 1, 8'h77, 8'h88);
        step(1, 0, 0, 0, 0, 0, 8'h99, 8'hAA);
        // R10/R7: drive B, live then stored
        step(0, 1, 0, 0, 0, 0, 8'hC3, 8'h00);
        step(0, 1, 0, 0, 0, 0, 8'h3C, 8'h00);
        step(0, 1, 1, 0, 0, 0, 8'hF0, 8'h00);
        // R2 with R7: strobe edge while live path passes data
        step(0, 1, 0, 0, 1, 0, 8'hE1, 8'h00);
        step(0, 1, 0, 0, 1, 0, 8'hE2, 8'h00);
        step(0, 1, 1, 0, 1, 0, 8'hE3, 8'h00);
        step(0, 1, 1, 0, 0, 0, 8'hE4, 8'h00);
        // R6: reverse direction
        step(0, 0, 1, 1, 0, 0, 8'h00, 8'h0F);
        step(0, 0, 1, 1, 0, 0, 8'h00, 8'h1E);
        step(0, 0, 1, 0, 0, 0, 8'h00, 8'h2D);
        // R3 with R8: B capture while port A is driven
        step(0, 0, 0, 1, 0, 1, 8'h00, 8'hB1);
        step(0, 0, 0, 1, 0, 1, 8'h00, 8'hB2);
        step(0, 0, 0, 1, 0, 1, 8'h00, 8'hB3);
        step(0, 0, 0, 1, 0, 0, 8'h00, 8'hB4);
        step(0, 1, 0, 1, 0, 0, 8'h12, 8'h00);
        step(0, 1, 1, 1, 0, 0, 8'h34, 8'h00);
        // Random run
        for (int i = 0; i < 3000; i++) begin
            logic oen, d;
            oen = ($urandom_range(0, 7) == 0);
            d   = (i / 9) % 2 == 0;
            step(oen, d, 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) == 0) ? ~stb_ab : stb_ab,
                 ($urandom_range(0, 3) == 0) ? ~stb_ba : stb_ba,
                 8'($urandom), 8'($urandom));
            if (i % 500 == 250) begin
                @(negedge clk); rst_n = 1'b0; #1 compare_all();
                step(oen, d, 1, 1, 0, 0, 8'h00, 8'h00);
                @(negedge clk); rst_n = 1'b1;
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule